// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer with Wait Extension

This block carries out a single access to an asynchronous memory. An access is made of three phases: address setup, strobe and hold. Each chip select has its own setup, read-strobe, write-strobe and hold cycle counts. A one-cycle `start_i` pulse begins the access, and `done_o` marks its end. During the access the block drives a one-hot chip select, a strobe-phase indicator and a write-enable level.

Each chip select can enable wait stretching. When it is enabled, a slow device can hold the strobe phase open through one of two wait inputs. Each chip select picks one of the two inputs, and each input has its own active level. A shared limit caps how long the strobe can be stretched. When the limit runs out, the block goes on to hold and gives a one-cycle timeout pulse for interrupt logic.

The data bus is parked: while idle and during writes the block drives the most recently written word. It releases the bus for the whole of a read's setup and strobe phases and drives the parked word again from the hold phase on.

Top module: `amem_seq`

## Requirements
- R1: After a `start_i` accepted while idle, the access begins on the next cycle. Setup lasts exactly the selected chip select's setup count; a count of 0 skips setup. Through setup, strobe and hold, `cs_o` has exactly bit `cs_i` set and `we_o` equals the latched `we_i`.
- R2: Without stretching, the strobe phase (`strobe_o` high) lasts the selected read or write strobe count. A count of 0 gives one strobe cycle.
- R3: Hold lasts the selected hold count (0 skips it). Then `done_o` is high for exactly one cycle with `cs_o` at 0, and `busy_o` is low in the cycle after that.
- R4: With stretching enabled, the wait level is first examined in the last programmed strobe cycle. While the wait input is active there, strobe cycles are added. A wait input that goes inactive ends the strobe two cycles after the change, because of a two-flop synchronizer.
- R5: Bit `c` of `wait_map_i` selects the wait input that chip select `c` watches. The other wait input has no effect on that chip select's accesses.
- R6: A wait input is active when its level equals its bit in `wait_pol_i` (0 means active low, 1 means active high).
- R7: At most `max_ext_i` cycles are added. If the wait input is still active when the limit is reached, `timeout_o` pulses for one cycle in the final strobe cycle and the access goes on to hold. When `max_ext_i` is 0, an active wait adds no cycles but still gives the pulse.
- R8: With stretching disabled for the selected chip select, the wait inputs have no effect and `timeout_o` stays low.
- R9: Starting an access whose stretching is enabled and whose selected strobe count is 0 raises `cfg_err_o` for one cycle, in the first access cycle. Such an access has a single strobe cycle and is never stretched.
- R10: From reset `data_o` is 0. While idle and during writes, `data_oe_o` is 1 and `data_o` holds the last written `wdata_i`, which takes effect from the first cycle of the write access.
- R11: For a read, `data_oe_o` is 0 from the first access cycle to the end of strobe and 1 again from the hold phase on. `rdata_o` holds `data_i` as sampled in the final strobe cycle.
- R12: `start_i` is ignored while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an access (sampled while idle) |
| cs_i | input | 2 | Chip select for the access |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 16 | Write data |
| setup_cyc_i | input | 16 | Per-chip-select setup counts, 4 bits each, chip select c at bits [4c+3:4c] |
| rd_strb_i | input | 24 | Per-chip-select read strobe counts, 6 bits each |
| wr_strb_i | input | 24 | Per-chip-select write strobe counts, 6 bits each |
| hold_cyc_i | input | 16 | Per-chip-select hold counts, 4 bits each |
| ext_en_i | input | 4 | Per-chip-select wait stretching enable |
| wait_map_i | input | 4 | Per-chip-select wait input select |
| wait_pol_i | input | 2 | Active level of each wait input |
| max_ext_i | input | 8 | Maximum number of added strobe cycles |
| wait_i | input | 2 | Asynchronous wait inputs |
| data_i | input | 16 | Memory read data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle end-of-access pulse |
| cs_o | output | 4 | One-hot chip select, active during the access |
| we_o | output | 1 | Write enable level during the access |
| strobe_o | output | 1 | Strobe phase indicator |
| timeout_o | output | 1 | One-cycle pulse when the stretch limit is hit |
| cfg_err_o | output | 1 | One-cycle pulse for a zero strobe with stretching enabled |
| data_o | output | 16 | Parked or write data to the bus |
| data_oe_o | output | 1 | Data bus output enable |
| rdata_o | output | 16 | Latched read data |

## Verification
The hardest case to reach from the ports is a wait input that goes inactive partway through a stretched strobe. The exit cycle then depends on the synchronizer latency and on when the level changes relative to the strobe count. The bench watches `strobe_o` cycle by cycle and drops the mapped wait input on the exact negative edge where a chosen number of strobe cycles has been seen. It then expects the strobe to end exactly two cycles later with no timeout. Random accesses with varied maps, polarities, limits and wait levels cover the remaining combinations.

// File: rtl/amem_pkg.sv
`timescale 1ns/1ps
package amem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STRB, PH_EXT, PH_HOLD, PH_DONE
  } phase_e;
endpackage

// File: rtl/amem_wait_sync.sv
`timescale 1ns/1ps
module amem_wait_sync #(
  parameter int unsigned NW     = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] d_i,
  output logic [NW-1:0] q_o
);
  logic [NW-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/amem_phase_fsm.sv
`timescale 1ns/1ps
module amem_phase_fsm
  import amem_pkg::*;
#(
  parameter int unsigned SW  = 4,
  parameter int unsigned STW = 6,
  parameter int unsigned MW  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [SW-1:0]  setup_len_i,
  input  logic [STW-1:0] strb_len_i,
  input  logic [SW-1:0]  hold_len_i,
  input  logic           ext_ok_i,
  input  logic           wait_act_i,
  input  logic [MW-1:0]  max_ext_i,
  output phase_e         phase_o,
  output logic           strb_end_o,
  output logic           timeout_o
);
  localparam int unsigned CW = (STW > SW) ? STW : SW;

  phase_e        ph_q, ph_d, post_ph;
  logic [CW-1:0] cnt_q, cnt_d, strb_eff, post_cnt;
  logic [MW-1:0] ext_q, ext_d;
  logic          strb_end, tmo;

  assign strb_eff = (strb_len_i == '0) ? CW'(1) : CW'(strb_len_i);
  assign post_ph  = (hold_len_i != '0) ? PH_HOLD : PH_DONE;
  assign post_cnt = CW'(hold_len_i);

  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    ext_d    = ext_q;
    strb_end = 1'b0;
    tmo      = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        if (setup_len_i != '0) begin
          ph_d  = PH_SETUP;
          cnt_d = CW'(setup_len_i);
        end else begin
          ph_d  = PH_STRB;
          cnt_d = strb_eff;
        end
      end
      PH_SETUP: if (cnt_q == CW'(1)) begin
        ph_d  = PH_STRB;
        cnt_d = strb_eff;
      end else cnt_d = cnt_q - 1'b1;
      PH_STRB: if (cnt_q == CW'(1)) begin
        // first look at wait level happens in last programmed cycle
        if (ext_ok_i && wait_act_i && max_ext_i != '0) begin
          ph_d  = PH_EXT;
          ext_d = MW'(1);
        end else begin
          tmo      = ext_ok_i && wait_act_i;
          strb_end = 1'b1;
          ph_d     = post_ph;
          cnt_d    = post_cnt;
        end
      end else cnt_d = cnt_q - 1'b1;
      PH_EXT: if (!wait_act_i || ext_q == max_ext_i) begin
        tmo      = wait_act_i;
        strb_end = 1'b1;
        ph_d     = post_ph;
        cnt_d    = post_cnt;
      end else ext_d = ext_q + 1'b1;
      PH_HOLD: if (cnt_q == CW'(1)) ph_d = PH_DONE;
               else cnt_d = cnt_q - 1'b1;
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      ext_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      ext_q <= ext_d;
    end
  end

  assign phase_o    = ph_q;
  assign strb_end_o = strb_end;
  assign timeout_o  = tmo;
endmodule

// File: rtl/amem_bus_park.sv
`timescale 1ns/1ps
module amem_bus_park #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_busy_i,
  input  logic          capture_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] park_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      park_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (load_i)    park_q  <= wdata_i;
      if (capture_i) rdata_q <= data_i;
    end
  end

  assign data_o    = park_q;
  assign data_oe_o = !rd_busy_i;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/amem_seq.sv
`timescale 1ns/1ps
module amem_seq
  import amem_pkg::*;
#(
  parameter int unsigned NCS = 4,
  parameter int unsigned NW  = 2,
  parameter int unsigned DW  = 16,
  parameter int unsigned SW  = 4,
  parameter int unsigned STW = 6,
  parameter int unsigned MW  = 8,
  localparam int unsigned CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int unsigned WSW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CSW-1:0]     cs_i,
  input  logic               we_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [NCS*SW-1:0]  setup_cyc_i,
  input  logic [NCS*STW-1:0] rd_strb_i,
  input  logic [NCS*STW-1:0] wr_strb_i,
  input  logic [NCS*SW-1:0]  hold_cyc_i,
  input  logic [NCS-1:0]     ext_en_i,
  input  logic [NCS*WSW-1:0] wait_map_i,
  input  logic [NW-1:0]      wait_pol_i,
  input  logic [MW-1:0]      max_ext_i,
  input  logic [NW-1:0]      wait_i,
  input  logic [DW-1:0]      data_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [NCS-1:0]     cs_o,
  output logic               we_o,
  output logic               strobe_o,
  output logic               timeout_o,
  output logic               cfg_err_o,
  output logic [DW-1:0]      data_o,
  output logic               data_oe_o,
  output logic [DW-1:0]      rdata_o
);
  logic [SW-1:0]  setup_a [NCS];
  logic [SW-1:0]  hold_a  [NCS];
  logic [STW-1:0] rd_a    [NCS];
  logic [STW-1:0] wr_a    [NCS];
  logic [WSW-1:0] map_a   [NCS];

  phase_e         phase;
  logic [CSW-1:0] cs_q, cs_sel;
  logic           we_q, we_sel, busy, acc_on, accept, cfg_err_q;
  logic [STW-1:0] strb_raw;
  logic [WSW-1:0] wsel;
  logic [NW-1:0]  wait_sync;
  logic           wait_act, ext_ok, strb_end, rd_busy;

  for (genvar c = 0; c < NCS; c++) begin : g_cfg
    assign setup_a[c] = setup_cyc_i[c*SW +: SW];
    assign hold_a[c]  = hold_cyc_i[c*SW +: SW];
    assign rd_a[c]    = rd_strb_i[c*STW +: STW];
    assign wr_a[c]    = wr_strb_i[c*STW +: STW];
    assign map_a[c]   = wait_map_i[c*WSW +: WSW];
    assign cs_o[c]    = acc_on && (cs_q == CSW'(c));
  end

  assign busy     = (phase != PH_IDLE);
  assign acc_on   = busy && (phase != PH_DONE);
  assign accept   = !busy && start_i;
  assign cs_sel   = busy ? cs_q : cs_i;
  assign we_sel   = busy ? we_q : we_i;
  assign strb_raw = we_sel ? wr_a[cs_sel] : rd_a[cs_sel];
  assign wsel     = map_a[cs_sel];
  assign wait_act = (wait_sync[wsel] == wait_pol_i[wsel]);
  assign ext_ok   = ext_en_i[cs_sel] && (strb_raw != '0);
  assign rd_busy  = !we_q && (phase == PH_SETUP || phase == PH_STRB || phase == PH_EXT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q      <= '0;
      we_q      <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      if (accept) begin
        cs_q <= cs_i;
        we_q <= we_i;
      end
      cfg_err_q <= accept && ext_en_i[cs_sel] && (strb_raw == '0);
    end
  end

  amem_wait_sync #(.NW(NW), .STAGES(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wait_i),
    .q_o   (wait_sync)
  );

  amem_phase_fsm #(.SW(SW), .STW(STW), .MW(MW)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .setup_len_i(setup_a[cs_sel]),
    .strb_len_i (strb_raw),
    .hold_len_i (hold_a[cs_sel]),
    .ext_ok_i   (ext_ok),
    .wait_act_i (wait_act),
    .max_ext_i  (max_ext_i),
    .phase_o    (phase),
    .strb_end_o (strb_end),
    .timeout_o  (timeout_o)
  );

  amem_bus_park #(.DW(DW)) i_park (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept && we_i),
    .wdata_i  (wdata_i),
    .rd_busy_i(rd_busy),
    .capture_i(strb_end && !we_q),
    .data_i   (data_i),
    .data_o   (data_o),
    .data_oe_o(data_oe_o),
    .rdata_o  (rdata_o)
  );

  assign busy_o    = busy;
  assign done_o    = (phase == PH_DONE);
  assign we_o      = acc_on && we_q;
  assign strobe_o  = (phase == PH_STRB) || (phase == PH_EXT);
  assign cfg_err_o = cfg_err_q;
endmodule

// File: rtl/amem_seq_chk.sv
`timescale 1ns/1ps
module amem_seq_chk #(
  parameter int unsigned NCS = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           busy_o,
  input logic           done_o,
  input logic [NCS-1:0] cs_o,
  input logic           we_o,
  input logic           strobe_o,
  input logic           timeout_o,
  input logic           cfg_err_o,
  input logic           data_oe_o
);
  // R1
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R7
  timeout_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> strobe_o);

  // R7
  timeout_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  // R9
  cfg_err_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $rose(busy_o));

  // R11
  release_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (busy_o && !we_o));

  // R11
  strobe_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !we_o) |-> !data_oe_o);

  // R12
  cs_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o != '0) |=> (cs_o == $past(cs_o)) || (cs_o == '0));
endmodule

bind amem_seq amem_seq_chk #(.NCS(NCS)) i_chk (.*);

// File: tb/test_amem_seq.sv
`timescale 1ns/1ps
module test_amem_seq;
  localparam int NCS = 4, NW = 2, DW = 16, SW = 4, STW = 6, MW = 8;

  logic clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic              rst_ni, start_i, we_i;
  logic [1:0]        cs_i;
  logic [DW-1:0]     wdata_i, data_i;
  logic [NCS*SW-1:0] setup_cyc, hold_cyc;
  logic [NCS*STW-1:0] rd_strb, wr_strb;
  logic [NCS-1:0]    ext_en, wait_map;
  logic [NW-1:0]     wait_pol, wait_raw;
  logic [MW-1:0]     max_ext;
  logic              busy_o, done_o, we_o, strobe_o, timeout_o, cfg_err_o, data_oe_o;
  logic [NCS-1:0]    cs_o;
  logic [DW-1:0]     data_o, rdata_o;

  amem_seq i_amem_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cs_i(cs_i), .we_i(we_i),
    .wdata_i(wdata_i), .setup_cyc_i(setup_cyc), .rd_strb_i(rd_strb), .wr_strb_i(wr_strb),
    .hold_cyc_i(hold_cyc), .ext_en_i(ext_en), .wait_map_i(wait_map), .wait_pol_i(wait_pol),
    .max_ext_i(max_ext), .wait_i(wait_raw), .data_i(data_i), .busy_o(busy_o),
    .done_o(done_o), .cs_o(cs_o), .we_o(we_o), .strobe_o(strobe_o), .timeout_o(timeout_o),
    .cfg_err_o(cfg_err_o), .data_o(data_o), .data_oe_o(data_oe_o), .rdata_o(rdata_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] last_wr = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cs(input int c, input int su, input int rs, input int ws, input int ho,
                        input bit ew, input bit mp);
    setup_cyc[c*SW +: SW]  = SW'(su);
    rd_strb[c*STW +: STW]  = STW'(rs);
    wr_strb[c*STW +: STW]  = STW'(ws);
    hold_cyc[c*SW +: SW]   = SW'(ho);
    ext_en[c]   = ew;
    wait_map[c] = mp;
  endtask

  function automatic int eff_strobe(input int s);
    return (s == 0) ? 1 : s;
  endfunction

  // rel_at > 0: drop the mapped wait input once that many strobe cycles are seen
  task automatic do_access(input int cs, input bit we, input logic [DW-1:0] wd,
                           input int rel_at, input bit keep_start, input string tag);
    int su, st, ho, mp, exp_st, exp_tmo, exp_err;
    int n_su, n_st, n_ho, n_tmo, n_err;
    bit act, ok_ext, seen, done, cs_bad, we_bad, oe_bad;
    logic [DW-1:0] pat;
    su = int'(setup_cyc[cs*SW +: SW]);
    ho = int'(hold_cyc[cs*SW +: SW]);
    st = we ? int'(wr_strb[cs*STW +: STW]) : int'(rd_strb[cs*STW +: STW]);
    mp = int'(wait_map[cs]);
    act = (wait_raw[mp] == wait_pol[mp]);
    ok_ext = ext_en[cs] && (st != 0);
    exp_err = (ext_en[cs] && st == 0) ? 1 : 0;
    if (rel_at > 0) begin
      exp_st = rel_at + 2; exp_tmo = 0;
    end else if (ok_ext && act) begin
      exp_st = eff_strobe(st) + int'(max_ext); exp_tmo = 1;
    end else begin
      exp_st = eff_strobe(st); exp_tmo = 0;
    end
    pat = DW'($urandom);
    repeat (3) @(negedge clk_i);
    start_i = 1'b1; cs_i = 2'(cs); we_i = we; wdata_i = wd; data_i = pat;
    @(negedge clk_i);
    if (keep_start) cs_i = 2'(cs + 1); else start_i = 1'b0;
    n_su = 0; n_st = 0; n_ho = 0; n_tmo = 0; n_err = 0;
    seen = 0; done = 0; cs_bad = 0; we_bad = 0; oe_bad = 0;
    for (int cyc = 0; cyc < 3000 && !done; cyc++) begin
      if (cyc > 0) @(negedge clk_i);
      if (done_o) begin
        done = 1;
      end else begin
        if (cs_o != NCS'(1 << cs)) cs_bad = 1;
        if (we_o != we) we_bad = 1;
        if (timeout_o) n_tmo++;
        if (cfg_err_o) n_err++;
        if (strobe_o) begin
          seen = 1; n_st++;
          if (rel_at > 0 && n_st == rel_at) wait_raw[mp] = ~wait_pol[mp];
        end else if (seen) n_ho++;
        else n_su++;
        if (we) begin
          if (!data_oe_o || data_o != wd) oe_bad = 1;
        end else if (!seen || strobe_o) begin
          if (data_oe_o) oe_bad = 1;
        end else if (!data_oe_o || data_o != last_wr) oe_bad = 1;
      end
    end
    chk(done, "R3", done, 1);
    chk(cs_o == '0, "R3", cs_o, 0);
    start_i = 1'b0;
    chk(n_su == su, "R1", n_su, su);
    chk(!cs_bad && !we_bad, "R1", {cs_bad, we_bad}, 0);
    chk(n_st == exp_st, tag, n_st, exp_st);
    chk(n_ho == ho, "R3", n_ho, ho);
    chk(n_tmo == exp_tmo, "R7", n_tmo, exp_tmo);
    chk(n_err == exp_err, "R9", n_err, exp_err);
    chk(!oe_bad, we ? "R10" : "R11", oe_bad, 0);
    if (!we) chk(rdata_o == pat, "R11", rdata_o, pat);
    else last_wr = wd;
    @(negedge clk_i);
    chk(!busy_o, "R12", busy_o, 0);
    chk(data_oe_o && data_o == last_wr, "R10", data_o, last_wr);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0; start_i = 1'b0; we_i = 1'b0; cs_i = '0; wdata_i = '0; data_i = '0;
    setup_cyc = '0; hold_cyc = '0; rd_strb = '0; wr_strb = '0; ext_en = '0; wait_map = '0;
    wait_pol = '0; wait_raw = 2'b11; max_ext = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state (R10, R3)
    chk(!busy_o && !done_o && cs_o == '0, "R3", busy_o, 0);
    chk(data_oe_o && data_o == '0, "R10", data_o, 0);
    chk(!timeout_o && !cfg_err_o, "R7", timeout_o, 0);

    // plain write and read, skipped phases, zero strobe (R1 R2 R3 R10 R11)
    set_cs(0, 2, 4, 3, 1, 0, 0);
    do_access(0, 1'b1, 16'hA5C3, 0, 0, "R2");
    set_cs(1, 0, 5, 2, 0, 0, 0);
    do_access(1, 1'b0, 16'h0, 0, 0, "R2");
    set_cs(2, 1, 0, 0, 2, 0, 0);
    do_access(2, 1'b0, 16'h0, 0, 0, "R2");

    // stretched to limit with active-high input 1 (R4 R6 R7)
    wait_pol = 2'b10; max_ext = 8'd5;
    set_cs(3, 1, 3, 2, 1, 1, 1);
    wait_raw = 2'b10;
    do_access(3, 1'b0, 16'h0, 0, 0, "R4");
    // active-low input 0 mapped
    wait_pol = 2'b00; wait_raw = 2'b10;
    set_cs(0, 0, 2, 2, 1, 1, 0);
    do_access(0, 1'b1, 16'h1234, 0, 0, "R6");
    // other input active, mapped inactive (R5)
    wait_pol = 2'b11; wait_raw = 2'b10;
    do_access(0, 1'b0, 16'h0, 0, 0, "R5");
    // stretching disabled, wait active (R8)
    set_cs(0, 1, 2, 4, 1, 0, 1);
    do_access(0, 1'b1, 16'h7E01, 0, 0, "R8");
    // limit zero (R7)
    max_ext = 8'd0;
    set_cs(0, 1, 3, 3, 1, 1, 1);
    do_access(0, 1'b0, 16'h0, 0, 0, "R7");
    // zero strobe with stretching (R9)
    max_ext = 8'd9;
    set_cs(1, 1, 0, 0, 1, 1, 1);
    do_access(1, 1'b1, 16'hBEEF, 0, 0, "R9");
    // release mid-stretch (R4)
    max_ext = 8'd40; wait_pol = 2'b11; wait_raw = 2'b11;
    set_cs(2, 1, 3, 3, 2, 1, 0);
    do_access(2, 1'b0, 16'h0, 5, 0, "R4");
    wait_raw = 2'b11;
    do_access(2, 1'b1, 16'h4321, 9, 0, "R4");
    // start held during access (R12)
    wait_raw = 2'b00;
    do_access(2, 1'b1, 16'h00FF, 0, 1, "R12");

    // constrained random
    for (int i = 0; i < 250; i++) begin
      if (i % 8 == 0) begin
        for (int c = 0; c < NCS; c++)
          set_cs(c, $urandom % 16, $urandom % 12, $urandom % 12, $urandom % 16,
                 1'($urandom), 1'($urandom));
        wait_pol = NW'($urandom);
        max_ext = MW'($urandom % 30);
      end
      wait_raw = NW'($urandom);
      do_access($urandom % NCS, 1'($urandom), DW'($urandom), 0, 1'($urandom % 6 == 0), "R2");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule